// File: doc/BRIEF.md
# Strobe-Driven Input FIFO

This block is a single-clock first-in first-out buffer that accepts 13-bit words from an external processor bus and passes them to logic inside the chip. The bus signals a write with two active-low signals: a chip select and a write strobe. Both are asynchronous to the system clock and stay low for several clock cycles. The block synchronizes the combined request and turns each bus access into exactly one stored word. The on-chip consumer pops words with a one-cycle read-enable pulse. It watches the full and empty flags and a sticky error flag. The error flag records any attempt to push into a full buffer or pop from an empty one.

The write side is a two-state machine. `CAP_IDLE` waits for the synchronized request. The transition `CAP_IDLE -> CAP_HOLD` fires on the first cycle in which the request is seen high, and that cycle issues the single write pulse. `CAP_HOLD` stays put while the request remains high. The transition `CAP_HOLD -> CAP_IDLE` fires once the synchronized request drops. Storage is a 256-entry circular array addressed by 8-bit pointers. One slot is always left unused, so the capacity is 255 words.

Top module: `strobe_fifo`

## Requirements
- R1: Words are 13 bits wide and leave `rd_data` in exactly the order they were accepted.
- R2: Starting from empty with no reads, `full` is low after 254 accepted writes and high after the 255th. `full` and `empty` are never high together.
- R3: While `rst_n` is low, and after it rises, `empty`=1, `full`=0, `err`=0 and `rd_data`=0. The reset is asynchronous.
- R4: A bus access exists only while both `bus_cs_n`=0 and `bus_wr_n`=0. Either signal alone being low stores nothing. One access stores exactly one word, however many cycles (three or more) it is held.
- R5: An access made while `full`=1 leaves the stored words and the head word unchanged, keeps `full`=1 and sets `err`.
- R6: A one-cycle `rd_en` pulse with `empty`=0 pops one word. `rd_data` updates on the rising edge that samples `rd_en`, so the word is valid by the following falling edge.
- R7: A `rd_en` pulse while `empty`=1 sets `err` and leaves `rd_data` and `empty` unchanged.
- R8: `err` stays high until reset, whatever later traffic occurs.
- R9: The pointers wrap. After 20 writes and 20 reads, 255 further writes make `full` high, and 255 reads return those words in order and leave `empty` high.
- R10: Accesses may start at any phase of the clock. The word on `bus_data` is captured three rising edges after the access begins, so the bus holds it stable while the strobe is low. Successive accesses are separated by at least three clock cycles of strobe high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_cs_n | input | 1 | Bus chip select, active low, asynchronous |
| bus_wr_n | input | 1 | Bus write strobe, active low, asynchronous |
| bus_data | input | 13 | Bus write data |
| rd_en | input | 1 | One-cycle pop request |
| rd_data | output | 13 | Most recently popped word |
| full | output | 1 | 255 words held |
| empty | output | 1 | No words held |
| err | output | 1 | Sticky overflow/underflow indicator |

## Verification
The state that is hardest to reach from the ports is the wrapped, completely full buffer. Reaching it takes hundreds of slow multi-cycle bus accesses after the pointers have been moved off zero. The stimulus first moves the pointers forward by 20 with short directed traffic. It then fills the buffer to 255 words with random data and a random strobe phase in each access. At that point it fires an extra access, to show that the head word survives and that `err` rises. A later random phase mixes pushes and pops around the middle of the range, and every popped word is checked against a queue model.

// File: rtl/dsf_pkg.sv
package dsf_pkg;
    typedef enum logic [0:0] {
        CAP_IDLE = 1'b0,
        CAP_HOLD = 1'b1
    } cap_state_t;
endpackage

// File: rtl/dsf_strobe_capture.sv
module dsf_strobe_capture
    import dsf_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bus_cs_n,
    input  logic bus_wr_n,
    output logic wr_pulse
);
    logic                   req_raw;
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   req_s;
    cap_state_t             state_q, state_d;

    assign req_raw = ~bus_cs_n & ~bus_wr_n;
    assign req_s   = sync_q[SYNC_STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], req_raw};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CAP_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d  = state_q;
        wr_pulse = 1'b0;
        unique case (state_q)
            CAP_IDLE: if (req_s) begin
                wr_pulse = 1'b1;
                state_d  = CAP_HOLD;
            end
            CAP_HOLD: if (!req_s) state_d = CAP_IDLE;
            default:  state_d = CAP_IDLE;
        endcase
    end

    // R4: one access yields one pulse, never two in a row
    p_single_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_pulse |=> !wr_pulse);
endmodule

// File: rtl/dsf_ptr_ctrl.sv
module dsf_ptr_ctrl #(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_req,
    input  logic          rd_req,
    output logic          wr_do,
    output logic          rd_do,
    output logic [AW-1:0] wptr,
    output logic [AW-1:0] rptr,
    output logic          full,
    output logic          empty,
    output logic          err
);
    localparam logic [AW-1:0] PTR_ONE = {{(AW-1){1'b0}}, 1'b1};

    assign full  = ((wptr + PTR_ONE) == rptr);
    assign empty = (wptr == rptr);
    assign wr_do = wr_req & ~full;
    assign rd_do = rd_req & ~empty;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr <= '0;
            rptr <= '0;
            err  <= 1'b0;
        end else begin
            if (wr_do) wptr <= wptr + PTR_ONE;
            if (rd_do) rptr <= rptr + PTR_ONE;
            if ((wr_req && full) || (rd_req && empty)) err <= 1'b1;
        end
    end

    p_flags_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(full && empty));
    p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && full && !rd_req) |=> (full && wptr == $past(wptr)));
    p_underflow_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && empty) |=> (err && rptr == $past(rptr)));
    p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);
endmodule

// File: rtl/dsf_store.sv
module dsf_store #(
    parameter int DW = 13,
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  rdata <= '0;
        else if (re) rdata <= mem[raddr];
    end
endmodule

// File: rtl/strobe_fifo.sv
module strobe_fifo #(
    parameter int DW          = 13,
    parameter int AW          = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_cs_n,
    input  logic          bus_wr_n,
    input  logic [DW-1:0] bus_data,
    input  logic          rd_en,
    output logic [DW-1:0] rd_data,
    output logic          full,
    output logic          empty,
    output logic          err
);
    logic          wr_pulse, wr_do, rd_do;
    logic [AW-1:0] wptr, rptr;

    dsf_strobe_capture #(.SYNC_STAGES(SYNC_STAGES)) u_cap (
        .clk(clk), .rst_n(rst_n), .bus_cs_n(bus_cs_n), .bus_wr_n(bus_wr_n),
        .wr_pulse(wr_pulse)
    );

    dsf_ptr_ctrl #(.AW(AW)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_req(wr_pulse), .rd_req(rd_en),
        .wr_do(wr_do), .rd_do(rd_do), .wptr(wptr), .rptr(rptr),
        .full(full), .empty(empty), .err(err)
    );

    dsf_store #(.DW(DW), .AW(AW)) u_store (
        .clk(clk), .rst_n(rst_n), .we(wr_do), .waddr(wptr), .wdata(bus_data),
        .re(rd_do), .raddr(rptr), .rdata(rd_data)
    );

    // R7: a pop on empty leaves the output word alone
    p_rd_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && empty) |=> $stable(rd_data));
endmodule

// File: tb/strobe_fifo_bench.sv
module strobe_fifo_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_cs_n = 1'b1;
    logic        bus_wr_n = 1'b1;
    logic [12:0] bus_data = '0;
    logic        rd_en = 1'b0;
    logic [12:0] rd_data;
    logic        full, empty, err;

    int n_tests = 0;
    int n_fail  = 0;
    logic [12:0] model [$];
    logic [12:0] last_out = '0;

    always #10 clk = ~clk;

    strobe_fifo u_strobe_fifo (
        .clk(clk), .rst_n(rst_n), .bus_cs_n(bus_cs_n), .bus_wr_n(bus_wr_n),
        .bus_data(bus_data), .rd_en(rd_en), .rd_data(rd_data),
        .full(full), .empty(empty), .err(err)
    );

    function automatic bit exp_full(int n);  return n == 255; endfunction
    function automatic bit exp_empty(int n); return n == 0;   endfunction

    task automatic check(string tag, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic check_flags(string tag, bit exp_err);
        check({tag, " full"},  full,  exp_full(model.size()));
        check({tag, " empty"}, empty, exp_empty(model.size()));
        check({tag, " err"},   err,   exp_err);
    endtask

    task automatic phase_wait();
        #($urandom_range(1, 18));
    endtask

    // cs/wr select which of the two strobes go low; hold in cycles
    task automatic bus_access(logic [12:0] v, bit cs, bit wr, int hold);
        @(posedge clk); phase_wait();
        bus_data = v; bus_cs_n = ~cs; bus_wr_n = ~wr;
        repeat (hold) @(posedge clk);
        phase_wait();
        bus_cs_n = 1'b1; bus_wr_n = 1'b1;
        repeat (3) @(posedge clk);
        if (cs && wr && model.size() < 255) model.push_back(v);
        @(negedge clk);
    endtask

    task automatic pop(string tag);
        logic [12:0] e;
        @(posedge clk); phase_wait();
        rd_en = 1'b1;
        @(posedge clk); #1 rd_en = 1'b0;
        @(negedge clk);
        if (model.size() > 0) e = model.pop_front(); else e = last_out;
        check(tag, rd_data, e);
        last_out = e;
    endtask

    task automatic do_reset();
        @(posedge clk); phase_wait();
        rst_n = 1'b0;
        @(negedge clk);
        check("R3 async dout", rd_data, 0);
        check("R3 async empty", empty, 1);
        repeat (2) @(posedge clk);
        phase_wait(); rst_n = 1'b1;
        model.delete(); last_out = '0;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #3 rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // R3 reset state
        check_flags("R3 reset", 0);
        check("R3 dout", rd_data, 0);

        // R4 partial strobes store nothing
        bus_access(13'h0AA, 1, 0, 4);
        bus_access(13'h0BB, 0, 1, 4);
        check("R4 cs-only/wr-only empty", empty, 1);
        // R4 long access is one word
        bus_access(13'h1234, 1, 1, 12);
        check_flags("R4 long hold", 0);
        pop("R4 single word R6");
        check("R4 one word only", empty, 1);

        // R9 move pointers by 20
        for (int i = 0; i < 20; i++) bus_access(13'(70 + i), 1, 1, 3);
        check_flags("R9 after 20", 0);
        for (int i = 0; i < 20; i++) pop("R9 R1 first 20");
        check_flags("R9 drained", 0);

        // R2 fill to 254 then 255
        for (int i = 0; i < 254; i++) bus_access(13'($urandom), 1, 1, 3 + ($urandom % 3));
        check("R2 254 not full", full, 0);
        bus_access(13'h1FFF, 1, 1, 3);
        check("R2 R9 255 full", full, 1);
        check("R2 not empty", empty, 0);
        // R5 overflow
        bus_access(13'h1ABC, 1, 1, 3);
        check("R5 still full", full, 1);
        check("R5 err set", err, 1);
        for (int i = 0; i < 255; i++) pop("R5 R9 R1 in-order");
        check("R9 empty after 255", empty, 1);
        check("R8 err sticky", err, 1);

        do_reset();
        check_flags("R3 re-reset", 0);
        // R7 underflow
        pop("R7 dout unchanged");
        check("R7 err", err, 1);
        check("R7 still empty", empty, 1);
        bus_access(13'h0123, 1, 1, 3);
        pop("R8 after traffic");
        check("R8 err held", err, 1);

        // R1 R10 random mix, no over/underflow
        do_reset();
        for (int k = 0; k < 300; k++) begin
            if (model.size() == 0 || (model.size() < 255 && $urandom % 2))
                bus_access(13'($urandom), 1, 1, 3 + ($urandom % 4));
            else
                pop("R1 R10 random");
            check("R2 random full", full, exp_full(model.size()));
            check("R2 random empty", empty, exp_empty(model.size()));
        end
        check("R10 no err", err, 0);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule